// File: doc/BRIEF.md
# Pausable-Clock Output Port Controller

This block sits between a locally clocked island and a neighbouring module and moves one word per request across a four-phase request/acknowledge link. It runs on a fast sampling clock. The island asks for a transfer by flipping a single toggle line; either direction of flip counts. The controller then works with the island's pausable clock generator through a pause request / pause grant pair, and with the partner through a request / acknowledge pair. When the link returns to rest, it reports completion on a done toggle.

Two orderings are supported and are picked per transfer by a mode input. In demand mode the island clock is frozen before the partner is asked, so the island cannot run ahead of the data. In poll mode the partner is asked first and the island keeps running. The clock is paused only for the short window after the partner answers, so the island must watch the done toggle to learn when the word has gone. A flip of the enable toggle that arrives while a transfer is still busy is reported on an error pulse and is dropped.

Top module: `hsk_port_ctrl`

## Requirements
- R1: Every change of level on `xfer_tog` (rising or falling) seen while the controller is at rest starts exactly one transfer. While `xfer_tog` holds its level, `hold_req` and `lnk_req` stay low and `done_tog` does not change.
- R2: In demand mode (`poll_mode`=0), `hold_req` rises before `lnk_req`. `lnk_req` is raised only after `hold_gnt` is seen high, and `hold_req` stays high for as long as `lnk_req` is high.
- R3: `lnk_req` stays high until `lnk_ack` is seen high. After that, `lnk_req` falls before `hold_req` falls.
- R4: `hold_req` falls only after `lnk_ack` has been seen low again. The transfer completes only once `hold_gnt` is seen low, and afterwards `hold_req` and `lnk_req` are both low.
- R5: On completion, `done_tog` takes the level that `xfer_tog` had when the transfer was launched. While a transfer is pending, `done_tog` differs from `xfer_tog`.
- R6: In poll mode (`poll_mode`=1), `lnk_req` rises first while `hold_req` is low.
- R7: In poll mode, `hold_req` stays low until `lnk_ack` has been seen high, and rises strictly after that.
- R8: A change on `xfer_tog` while a transfer is busy raises `err_pulse` for one cycle and is not queued. `done_tog` then finishes at the first transfer's level, and no further request follows.
- R9: A change on `xfer_tog` that arrives in the very cycle a transfer completes is accepted without error. It starts the next transfer at once, and `done_tog` still shows the previous transfer's completion.
- R10: While reset is asserted and right after reset, `hold_req`, `lnk_req`, `done_tog` and `err_pulse` are low.
- R11: `lnk_ack` and `hold_gnt` pass through `SYNC_STAGES` flops before the controller acts on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_mode | input | 1 | 0 = demand ordering, 1 = poll ordering; latched at launch |
| xfer_tog | input | 1 | Two-phase transfer request from an island register |
| done_tog | output | 1 | Completion toggle, equals launching level of `xfer_tog` |
| hold_req | output | 1 | Pause request to the island clock generator |
| hold_gnt | input | 1 | Pause grant from the island clock generator |
| lnk_req | output | 1 | Four-phase request to the partner module |
| lnk_ack | input | 1 | Four-phase acknowledge from the partner module |
| err_pulse | output | 1 | One-cycle flag for a request flip while busy |

## Verification
Two events can land in the same cycle. One is the completion of a transfer, when the synchronised pause grant falls. The other is a fresh flip of the enable toggle. The bench forces this overlap by driving both handshakes by hand: it drops the grant, then flips the toggle exactly the number of synchroniser stages later. It then judges that no error pulse appears, that the pause request is raised again in the next cycle, and that the done toggle shows the previous level before it moves to the new one.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // at rest
    ST_PAUSE,  // demand: pause asked, waiting for grant
    ST_REQ,    // request out, waiting for acknowledge
    ST_GRAB,   // poll: acknowledge seen, pause asked, waiting for grant
    ST_DROP,   // request withdrawn, waiting for acknowledge to fall
    ST_FREE    // pause released, waiting for grant to fall
  } hsk_state_e;

  function automatic hsk_state_e fn_start(input logic poll);
    return poll ? ST_REQ : ST_PAUSE;
  endfunction

  function automatic logic fn_drive_ri(input hsk_state_e s, input logic poll);
    return (s == ST_PAUSE) || (s == ST_GRAB) || (s == ST_DROP) ||
           ((s == ST_REQ) && !poll);
  endfunction

  function automatic logic fn_drive_req(input hsk_state_e s);
    return (s == ST_REQ) || (s == ST_GRAB);
  endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2+1-1:0], d} >> 0;
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hsk_edge.sv
module hsk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic flip
);
  logic lvl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end
  assign flip = lvl ^ lvl_q;
endmodule

// File: rtl/hsk_fsm.sv
module hsk_fsm
  import hsk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic lvl,
  input  logic poll_mode,
  input  logic ack_s,
  input  logic gnt_s,
  output logic hold_req,
  output logic lnk_req,
  output logic done_tog,
  output logic err_pulse,
  output logic xfer_poll
);
  hsk_state_e st, nx;
  logic lvl_q;
  logic fin, idle_like, launch, clash, nx_poll;

  always_comb begin
    fin       = (st == ST_FREE) && !gnt_s;
    idle_like = (st == ST_IDLE) || fin;
    launch    = flip && idle_like;
    clash     = flip && !idle_like;
    nx_poll   = launch ? poll_mode : xfer_poll;
  end

  always_comb begin
    nx = st;
    case (st)
      ST_IDLE:  if (launch) nx = fn_start(poll_mode);
      ST_PAUSE: if (gnt_s)  nx = ST_REQ;
      ST_REQ:   if (ack_s)  nx = xfer_poll ? ST_GRAB : ST_DROP;
      ST_GRAB:  if (gnt_s)  nx = ST_DROP;
      ST_DROP:  if (!ack_s) nx = ST_FREE;
      ST_FREE:  if (fin)    nx = launch ? fn_start(poll_mode) : ST_IDLE;
      default:              nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      xfer_poll <= 1'b0;
      lvl_q     <= 1'b0;
      done_tog  <= 1'b0;
      err_pulse <= 1'b0;
      hold_req  <= 1'b0;
      lnk_req   <= 1'b0;
    end else begin
      st        <= nx;
      xfer_poll <= nx_poll;
      err_pulse <= clash;
      hold_req  <= fn_drive_ri(nx, nx_poll);
      lnk_req   <= fn_drive_req(nx);
      if (launch) lvl_q <= lvl;
      if (fin)    done_tog <= lvl_q;
    end
  end
endmodule

// File: rtl/hsk_port_ctrl.sv
module hsk_port_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_mode,
  input  logic xfer_tog,
  output logic done_tog,
  output logic hold_req,
  input  logic hold_gnt,
  output logic lnk_req,
  input  logic lnk_ack,
  output logic err_pulse
);
  logic ack_s;
  logic gnt_s;
  logic flip;
  logic xfer_poll;

  hsk_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(lnk_ack), .q(ack_s)
  );

  hsk_sync #(.STAGES(SYNC_STAGES)) u_gnt_sync (
    .clk(clk), .rst_n(rst_n), .d(hold_gnt), .q(gnt_s)
  );

  hsk_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(xfer_tog), .flip(flip)
  );

  hsk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .flip(flip), .lvl(xfer_tog),
    .poll_mode(poll_mode), .ack_s(ack_s), .gnt_s(gnt_s),
    .hold_req(hold_req), .lnk_req(lnk_req), .done_tog(done_tog),
    .err_pulse(err_pulse), .xfer_poll(xfer_poll)
  );
endmodule

// File: rtl/hsk_port_ctrl_chk.sv
module hsk_port_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req,
  input logic lnk_req,
  input logic done_tog,
  input logic ack_s,
  input logic xfer_poll
);
  // R2: demand-mode request only ever appears under a held pause
  a_r2_req_under_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && !xfer_poll) |-> hold_req);

  // R3: request is not withdrawn before the acknowledge is seen
  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && !ack_s) |=> lnk_req);

  // R4: pause is released only once the acknowledge has gone low
  a_r4_ri_falls_late: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> !ack_s);

  // R7: poll mode keeps the island running until acknowledge arrives
  a_r7_poll_no_early_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_poll && lnk_req && !ack_s) |-> !hold_req);

  // R5: done toggle moves only after a cycle with the link at rest
  a_r5_done_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(done_tog) |-> ($past(!lnk_req) && $past(!hold_req)));
endmodule

bind hsk_port_ctrl hsk_port_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .lnk_req(lnk_req),
  .done_tog(done_tog), .ack_s(ack_s), .xfer_poll(xfer_poll)
);

// File: tb/hsk_port_ctrl_tb_top.sv
module hsk_port_ctrl_tb_top;
  localparam int SYNC = 2;
  // vector: {poll_mode, ack_dly[3:0], ai_dly[3:0]}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 4'd0, 4'd0}, {1'b0, 4'd5, 4'd2}, {1'b0, 4'd1, 4'd7},
    {1'b1, 4'd0, 4'd0}, {1'b1, 4'd6, 4'd1}, {1'b1, 4'd2, 4'd5},
    {1'b0, 4'd3, 4'd3}, {1'b1, 4'd9, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll_mode = 1'b0;
  logic xfer_tog = 1'b0;
  logic hold_gnt = 1'b0;
  logic lnk_ack = 1'b0;
  logic done_tog, hold_req, lnk_req, err_pulse;

  always #10 clk = ~clk;

  hsk_port_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll_mode(poll_mode), .xfer_tog(xfer_tog),
    .done_tog(done_tog), .hold_req(hold_req), .hold_gnt(hold_gnt),
    .lnk_req(lnk_req), .lnk_ack(lnk_ack), .err_pulse(err_pulse)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit auto_en = 0;
  int ack_dly = 0, ai_dly = 0;
  int cyc = 0;
  int ri_rise, req_rise, ack_rise, ri_fall, req_fall;
  bit err_seen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_marks();
    ri_rise = -1; req_rise = -1; ack_rise = -1; ri_fall = -1; req_fall = -1;
  endtask

  // responders and monitor, all at the falling edge
  initial begin
    int ca = 0, cg = 0;
    logic ri_p = 0, rq_p = 0;
    clr_marks();
    forever begin
      @(negedge clk);
      cyc++;
      if (err_pulse) err_seen = 1;
      if (hold_req && !ri_p && ri_rise < 0) ri_rise = cyc;
      if (!hold_req && ri_p && ri_fall < 0) ri_fall = cyc;
      if (lnk_req && !rq_p && req_rise < 0) req_rise = cyc;
      if (!lnk_req && rq_p && req_fall < 0) req_fall = cyc;
      ri_p = hold_req; rq_p = lnk_req;
      if (auto_en) begin
        if (hold_gnt != hold_req) begin
          if (cg >= ai_dly) begin hold_gnt = hold_req; cg = 0; end else cg++;
        end else cg = 0;
        if (lnk_ack != lnk_req) begin
          if (ca >= ack_dly) begin
            lnk_ack = lnk_req; ca = 0;
            if (lnk_req && ack_rise < 0) ack_rise = cyc;
          end else ca++;
        end else ca = 0;
      end
    end
  end

  task automatic wait_for(input int sel, input logic v, input string tag);
    logic s;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      s = (sel == 0) ? hold_req : (sel == 1) ? lnk_req : done_tog;
      if (s == v) return;
    end
    chk(0, tag, int'(!v), int'(v));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!hold_req && !lnk_req && !done_tog && !err_pulse, "R10 outputs in reset",
        {hold_req, lnk_req, done_tog, err_pulse}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!hold_req && !lnk_req && !done_tog && !err_pulse, "R10 outputs after reset",
        {hold_req, lnk_req, done_tog, err_pulse}, 0);

    // R1: steady enable level does nothing
    auto_en = 1;
    clr_marks();
    repeat (20) @(negedge clk);
    chk(ri_rise < 0 && req_rise < 0 && done_tog == xfer_tog, "R1 steady level idle",
        ri_rise, -1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic pm;
      pm = VEC[v][8];
      ack_dly = int'(VEC[v][7:4]);
      ai_dly = int'(VEC[v][3:0]);
      poll_mode = pm;
      clr_marks();
      xfer_tog = ~xfer_tog;  // R1: alternates rising and falling flips
      @(negedge clk);
      chk(done_tog != xfer_tog, $sformatf("R5 pending v%0d", v), done_tog, !xfer_tog);
      wait_for(2, xfer_tog, $sformatf("R5 completion v%0d", v));
      chk(done_tog == xfer_tog, $sformatf("R5 done level v%0d", v), done_tog, xfer_tog);
      if (!pm) begin
        chk(ri_rise >= 0 && ri_rise < req_rise, $sformatf("R2 pause first v%0d", v),
            ri_rise, req_rise - 1);
      end else begin
        chk(req_rise >= 0 && req_rise < ri_rise, $sformatf("R6 request first v%0d", v),
            req_rise, ri_rise - 1);
        chk(ack_rise >= 0 && ri_rise > ack_rise, $sformatf("R7 pause after ack v%0d", v),
            ri_rise, ack_rise + 1);
      end
      chk(req_fall >= 0 && req_fall < ri_fall, $sformatf("R3 req drops before ri v%0d", v),
          req_fall, ri_fall - 1);
      chk(!hold_req && !lnk_req, $sformatf("R4 link at rest v%0d", v),
          {hold_req, lnk_req}, 0);
      repeat (3) @(negedge clk);
    end

    // R8: flip while busy
    poll_mode = 0; ack_dly = 10; ai_dly = 0;
    err_seen = 0;
    xfer_tog = ~xfer_tog;
    repeat (3) @(negedge clk);
    xfer_tog = ~xfer_tog;
    repeat (60) @(negedge clk);
    chk(err_seen, "R8 error pulse raised", int'(err_seen), 1);
    chk(done_tog != xfer_tog, "R8 done at first level", done_tog, !xfer_tog);
    clr_marks();
    repeat (30) @(negedge clk);
    chk(req_rise < 0 && !hold_req, "R8 flip not queued", req_rise, -1);
    xfer_tog = ~xfer_tog;  // resync: now equals done_tog, launches one transfer
    repeat (60) @(negedge clk);
    chk(done_tog == xfer_tog && !hold_req && !lnk_req, "R8 resync", done_tog, xfer_tog);

    // R9: new flip in the completion cycle (manual handshakes)
    auto_en = 0; ack_dly = 0; ai_dly = 0;
    poll_mode = 0;
    err_seen = 0;
    @(negedge clk);
    xfer_tog = ~xfer_tog;
    wait_for(0, 1'b1, "R9 pause asked");
    hold_gnt = 1'b1;
    wait_for(1, 1'b1, "R9 request out");
    lnk_ack = 1'b1;
    wait_for(1, 1'b0, "R9 request dropped");
    lnk_ack = 1'b0;
    wait_for(0, 1'b0, "R9 pause released");
    hold_gnt = 1'b0;
    repeat (SYNC) @(negedge clk);
    xfer_tog = ~xfer_tog;
    @(negedge clk);
    chk(done_tog != xfer_tog, "R9 previous completion shown", done_tog, !xfer_tog);
    chk(hold_req, "R9 next transfer launched", int'(hold_req), 1);
    chk(!err_seen, "R9 no error", int'(err_seen), 0);
    auto_en = 1;
    wait_for(2, xfer_tog, "R9 second completion");
    chk(done_tog == xfer_tog, "R9 second done", done_tog, xfer_tog);

    // R11: acknowledge needs SYNC flops before it is acted on
    auto_en = 0;
    poll_mode = 1;
    @(negedge clk);
    xfer_tog = ~xfer_tog;
    wait_for(1, 1'b1, "R11 poll request");
    lnk_ack = 1'b1;
    repeat (SYNC) @(negedge clk);
    chk(!hold_req, "R11 ack not acted on early", int'(hold_req), 0);
    @(negedge clk);
    chk(hold_req, "R11 ack acted on after sync", int'(hold_req), 1);
    hold_gnt = 1'b1;
    wait_for(1, 1'b0, "R11 request dropped");
    lnk_ack = 1'b0;
    wait_for(0, 1'b0, "R11 pause released");
    hold_gnt = 1'b0;
    wait_for(2, xfer_tog, "R11 completion");

    finished = 1;
    summary();
  end
endmodule